// File: doc/BRIEF.md
# Reference-Window Frequency Meter

This block measures the rate of one oscillator, picked from a bank of free-running clock inputs. The oscillator's rising edges are counted over a fixed gate window that a 26 MHz reference clock times. The window lasts 1/26,624 s. A result of N therefore means a frequency of about N × 26,624 Hz, or N × 26,624 × (D+1) Hz when the edges pass through a pre-divisor of D+1.

The control fields are the ones a register word would hold: an enable bit, a start strobe that sets a self-clearing busy/run flag, a 6-bit source index, an 8-bit pre-divisor and a 2-bit routing-mode field. The count and the pre-divisor run in the measured clock domain. The count is passed to the reference domain as a Gray code, and it is loaded into the result register at the same edge on which the run flag clears. Software sets enable, pulses start, waits for the run flag to drop and then reads the result.

Top module: `refwin_freq_meter`

## Requirements
- R1: After reset `run_busy` is 0 and `count_out` is 0.
- R2: A `ctl_start` pulse starts a measurement only when `ctl_enable` is 1 and no measurement is in progress. A pulse while `ctl_enable` is 0 leaves `run_busy` at 0. A pulse during a measurement does not extend or restart it.
- R3: `run_busy` rises on the edge after an accepted start and stays 1 for exactly ARM_CYC + GATE_CYC + DRAIN_CYC reference cycles (4 + 977 + 16 = 997 with the defaults). `count_out` takes its new value on the same edge on which `run_busy` clears, and it does not change at any other time.
- R4: The gate window lasts GATE_CYC = round(REF_HZ / 26,624) reference cycles, which is 977 for 26 MHz. The number of rising edges of the selected oscillator counted in that window is within ±2 of window length / oscillator period. The count reaches the reference domain through a Gray-coded path.
- R5: A pre-divisor value D counts one step per D+1 oscillator edges, so the result is floor(edges/(D+1)) within that same tolerance. D = 0 means divide by 1.
- R6: The source index i selects `osc_clk[i]`. An index of N_SRC or above selects no clock, and the result is 0.
- R7: Any routing-mode value other than 2'b00 blocks the clock from the meter, and the result is 0.
- R8: When `ctl_enable` is 0 at a clock edge, any measurement is aborted: `run_busy` is 0 after that edge and `count_out` keeps its previous value.
- R9: The count saturates at 2^CNT_W − 1 and does not wrap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | 26 MHz reference clock |
| ref_rst_n | input | 1 | Active-low reset, reference domain |
| osc_clk | input | N_SRC | Oscillator clocks that can be measured |
| ctl_enable | input | 1 | Meter enable; 0 aborts a measurement |
| ctl_start | input | 1 | One-cycle strobe that sets the run flag |
| ctl_src_sel | input | 6 | Index of the oscillator to measure |
| ctl_prediv | input | 8 | Pre-divisor D; the edges are divided by D+1 |
| ctl_route | input | 2 | Routing mode; only 2'b00 passes the clock |
| run_busy | output | 1 | Run flag; clears itself when the count is done |
| count_out | output | CNT_W | Last completed measurement result |

## Verification
The hardest case to reach is a saturated count. With the default 16-bit counter, saturation needs an oscillator above 1.7 GHz. The bench therefore narrows the counter to 12 bits and measures a 250 MHz source with divide-by-1, which overfills it more than twice. The abort case is also hard to reach. It needs a measurement that is deep inside its gate window, which the bench gets by dropping enable hundreds of cycles after start. It then checks that the run flag clears at once and that the earlier, non-zero result stays in place. Random sources, divisors and routing modes, including source indices that do not exist, cover the remaining field combinations against windows computed in the bench.

// File: rtl/fm_pkg.sv
`timescale 1ns/1ps
package fm_pkg;
   typedef enum logic [1:0] {
      ST_IDLE,
      ST_ARM,
      ST_GATE,
      ST_DRAIN
   } fm_state_e;

   localparam int FM_SEL_W = 6;
   localparam int FM_DIV_W = 8;
   localparam int FM_RT_W  = 2;
endpackage

// File: rtl/fm_edge_count.sv
`timescale 1ns/1ps
module fm_edge_count #(
   parameter int CNT_W = 16,
   parameter int DIV_W = 8
) (
   input  logic             meas_clk,
   input  logic             clr_i,
   input  logic             gate_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [CNT_W-1:0] gray_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic             gate_m1, gate_m2;
   logic [DIV_W-1:0] div_cnt;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] gray_q;

   always_ff @(posedge meas_clk or posedge clr_i) begin
      if (clr_i) begin
         gate_m1 <= 1'b0;
         gate_m2 <= 1'b0;
         div_cnt <= '0;
         cnt_q   <= '0;
         gray_q  <= '0;
      end else begin
         gate_m1 <= gate_i;
         gate_m2 <= gate_m1;
         gray_q  <= cnt_q ^ (cnt_q >> 1);
         if (gate_m2) begin
            if (div_cnt == div_i) begin
               div_cnt <= '0;
               if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            end else begin
               div_cnt <= div_cnt + 1'b1;
            end
         end
      end
   end

   assign gray_o = gray_q;

   AST_SAT_HOLD: assert property (@(posedge meas_clk) disable iff (clr_i)
      (cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX)); // R9
   AST_GRAY_STEP: assert property (@(posedge meas_clk) disable iff (clr_i)
      $countones(gray_q ^ $past(gray_q)) <= 1); // R4
endmodule

// File: rtl/fm_gray_sync.sv
`timescale 1ns/1ps
module fm_gray_sync #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] gray_i,
   output logic [W-1:0] bin_o
);
   logic [W-1:0] s1, s2;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1 <= '0;
         s2 <= '0;
      end else begin
         s1 <= gray_i;
         s2 <= s1;
      end
   end

   always_comb begin
      bin_o[W-1] = s2[W-1];
      for (int k = W - 2; k >= 0; k--) bin_o[k] = bin_o[k+1] ^ s2[k];
   end
endmodule

// File: rtl/fm_gate_ctrl.sv
`timescale 1ns/1ps
module fm_gate_ctrl import fm_pkg::*; #(
   parameter int N_SRC     = 4,
   parameter int CNT_W     = 16,
   parameter int SEL_W     = FM_SEL_W,
   parameter int DIV_W     = FM_DIV_W,
   parameter int RT_W      = FM_RT_W,
   parameter int GATE_CYC  = 977,
   parameter int ARM_CYC   = 4,
   parameter int DRAIN_CYC = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctl_enable,
   input  logic             ctl_start,
   input  logic [SEL_W-1:0] ctl_src_sel,
   input  logic [DIV_W-1:0] ctl_prediv,
   input  logic [RT_W-1:0]  ctl_route,
   input  logic [CNT_W-1:0] sync_count,
   output logic             run_busy,
   output logic [CNT_W-1:0] count_out,
   output logic [SEL_W-1:0] cfg_src,
   output logic [DIV_W-1:0] cfg_div,
   output logic             cfg_pass,
   output logic             clr_o,
   output logic             gate_o
);
   localparam int TMR_A   = (GATE_CYC > ARM_CYC) ? GATE_CYC : ARM_CYC;
   localparam int TMR_MAX = (TMR_A > DRAIN_CYC) ? TMR_A : DRAIN_CYC;
   localparam int TMR_W   = $clog2(TMR_MAX + 1);
   localparam int GL_W    = $clog2(GATE_CYC + 2);
   localparam logic [TMR_W-1:0] ARM_END   = TMR_W'(ARM_CYC - 1);
   localparam logic [TMR_W-1:0] GATE_END  = TMR_W'(GATE_CYC - 1);
   localparam logic [TMR_W-1:0] DRAIN_END = TMR_W'(DRAIN_CYC - 1);
   localparam logic [SEL_W:0]   SRC_LIM   = (SEL_W + 1)'(N_SRC);

   fm_state_e        st;
   logic [TMR_W-1:0] tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_IDLE;
         tmr       <= '0;
         run_busy  <= 1'b0;
         count_out <= '0;
         cfg_src   <= '0;
         cfg_div   <= '0;
         cfg_pass  <= 1'b0;
         clr_o     <= 1'b0;
         gate_o    <= 1'b0;
      end else if (!ctl_enable) begin
         st       <= ST_IDLE;
         tmr      <= '0;
         run_busy <= 1'b0;
         clr_o    <= 1'b0;
         gate_o   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: if (ctl_start) begin
               cfg_src  <= ctl_src_sel;
               cfg_div  <= ctl_prediv;
               cfg_pass <= (ctl_route == '0) && ({1'b0, ctl_src_sel} < SRC_LIM);
               st       <= ST_ARM;
               tmr      <= '0;
               clr_o    <= 1'b1;
               run_busy <= 1'b1;
            end
            ST_ARM: if (tmr == ARM_END) begin
               clr_o  <= 1'b0;
               gate_o <= 1'b1;
               tmr    <= '0;
               st     <= ST_GATE;
            end else tmr <= tmr + 1'b1;
            ST_GATE: if (tmr == GATE_END) begin
               gate_o <= 1'b0;
               tmr    <= '0;
               st     <= ST_DRAIN;
            end else tmr <= tmr + 1'b1;
            ST_DRAIN: if (tmr == DRAIN_END) begin
               count_out <= sync_count;
               run_busy  <= 1'b0;
               tmr       <= '0;
               st        <= ST_IDLE;
            end else tmr <= tmr + 1'b1;
            default: st <= ST_IDLE;
         endcase
      end
   end

   // window-length checker
   logic [GL_W-1:0] glen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      glen <= '0;
      else if (gate_o) glen <= glen + 1'b1;
      else             glen <= '0;
   end

   AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_enable |=> !run_busy); // R8
   AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_busy) |-> $past(ctl_enable && ctl_start)); // R2
   AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      run_busy |-> $stable(count_out)); // R3
   AST_GATE_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(gate_o) && $past(ctl_enable)) |-> (glen == GL_W'(GATE_CYC))); // R4
endmodule

// File: rtl/refwin_freq_meter.sv
`timescale 1ns/1ps
module refwin_freq_meter import fm_pkg::*; #(
   parameter int N_SRC     = 4,
   parameter int CNT_W     = 16,
   parameter int REF_HZ    = 26_000_000,
   parameter int WIN_HZ    = 26_624,
   parameter int TOL_PPM   = 1000,
   parameter int ARM_CYC   = 4,
   parameter int DRAIN_CYC = 16
) (
   input  logic                ref_clk,
   input  logic                ref_rst_n,
   input  logic [N_SRC-1:0]    osc_clk,
   input  logic                ctl_enable,
   input  logic                ctl_start,
   input  logic [FM_SEL_W-1:0] ctl_src_sel,
   input  logic [FM_DIV_W-1:0] ctl_prediv,
   input  logic [FM_RT_W-1:0]  ctl_route,
   output logic                run_busy,
   output logic [CNT_W-1:0]    count_out
);
   localparam longint GATE_L = (longint'(REF_HZ) + longint'(WIN_HZ / 2)) / longint'(WIN_HZ);
   localparam int     GATE_CYC = int'(GATE_L);
   localparam longint PROD_L = GATE_L * longint'(WIN_HZ);
   localparam longint ERR_L  = (PROD_L > longint'(REF_HZ)) ? PROD_L - longint'(REF_HZ)
                                                            : longint'(REF_HZ) - PROD_L;

   if (N_SRC < 1 || N_SRC > 64) begin : g_bad_nsrc
      $error("N_SRC must lie in 1..64");
   end
   if (CNT_W < 2) begin : g_bad_cntw
      $error("CNT_W must be at least 2");
   end
   if (ARM_CYC < 2 || DRAIN_CYC < 8) begin : g_bad_phase
      $error("ARM_CYC must be >= 2 and DRAIN_CYC >= 8");
   end
   if (ERR_L * 64'd1_000_000 > longint'(TOL_PPM) * longint'(REF_HZ)) begin : g_bad_tol
      $error("gate window error exceeds TOL_PPM");
   end

   logic [FM_SEL_W-1:0] cfg_src;
   logic [FM_DIV_W-1:0] cfg_div;
   logic                cfg_pass;
   logic                clr_q, gate_q;
   logic                sel_clk, meas_clk, osc_clr;
   logic [CNT_W-1:0]    gray_w, sync_bin;

   if (N_SRC == 1) begin : g_one_src
      assign sel_clk = osc_clk[0];
   end else begin : g_mux_src
      localparam int IDX_W = $clog2(N_SRC);
      assign sel_clk = osc_clk[cfg_src[IDX_W-1:0]];
   end

   assign meas_clk = sel_clk & cfg_pass;
   assign osc_clr  = ~ref_rst_n | clr_q;

   fm_gate_ctrl #(
      .N_SRC(N_SRC), .CNT_W(CNT_W), .SEL_W(FM_SEL_W), .DIV_W(FM_DIV_W),
      .RT_W(FM_RT_W), .GATE_CYC(GATE_CYC), .ARM_CYC(ARM_CYC), .DRAIN_CYC(DRAIN_CYC)
   ) u_ctrl (
      .clk(ref_clk), .rst_n(ref_rst_n),
      .ctl_enable(ctl_enable), .ctl_start(ctl_start),
      .ctl_src_sel(ctl_src_sel), .ctl_prediv(ctl_prediv), .ctl_route(ctl_route),
      .sync_count(sync_bin),
      .run_busy(run_busy), .count_out(count_out),
      .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_pass(cfg_pass),
      .clr_o(clr_q), .gate_o(gate_q)
   );

   fm_edge_count #(.CNT_W(CNT_W), .DIV_W(FM_DIV_W)) u_cnt (
      .meas_clk(meas_clk), .clr_i(osc_clr), .gate_i(gate_q),
      .div_i(cfg_div), .gray_o(gray_w)
   );

   fm_gray_sync #(.W(CNT_W)) u_sync (
      .clk(ref_clk), .rst_n(ref_rst_n), .gray_i(gray_w), .bin_o(sync_bin)
   );
endmodule

// File: tb/refwin_freq_meter_bench.sv
`timescale 1ns/1ps
module refwin_freq_meter_bench;
   localparam int REF_PERIOD_NS = 38;
   localparam int CNT_W    = 12;
   localparam int CMAX     = (1 << CNT_W) - 1;
   localparam int ARM_C    = 4;
   localparam int DRAIN_C  = 16;
   localparam int GATE_C   = (26_000_000 + 13_312) / 26_624;
   localparam int BUSY_LEN = ARM_C + GATE_C + DRAIN_C;
   localparam int GATE_NS  = GATE_C * REF_PERIOD_NS;
   localparam int WDOG     = 190_000;
   localparam int OSC_PER [4] = '{4, 10, 26, 50};

   logic       clk = 1'b0, rst_n = 1'b0;
   logic [3:0] osc = '0;
   logic       en = 1'b0, start = 1'b0;
   logic [5:0] src = '0;
   logic [7:0] pre = '0;
   logic [1:0] rt  = '0;
   logic       busy;
   logic [CNT_W-1:0] cnt;

   int total = 0, bad = 0, cyc = 0;

   refwin_freq_meter #(.N_SRC(4), .CNT_W(CNT_W), .ARM_CYC(ARM_C), .DRAIN_CYC(DRAIN_C))
   u_refwin_freq_meter (
      .ref_clk(clk), .ref_rst_n(rst_n), .osc_clk(osc), .ctl_enable(en),
      .ctl_start(start), .ctl_src_sel(src), .ctl_prediv(pre), .ctl_route(rt),
      .run_busy(busy), .count_out(cnt)
   );

   always #(REF_PERIOD_NS / 2.0) clk = ~clk;
   initial begin #0.31; forever #2.0  osc[0] = ~osc[0]; end
   initial begin #0.77; forever #5.0  osc[1] = ~osc[1]; end
   initial begin #1.13; forever #13.0 osc[2] = ~osc[2]; end
   initial begin #2.41; forever #25.0 osc[3] = ~osc[3]; end

   task automatic chk(input bit ok, input string tag, input int got, input int expv);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: got %0d expected %0d", tag, got, expv);
      end
   endtask

   function automatic int exp_lo(input int s, input int p, input int r);
      int e;
      if (r != 0 || s >= 4) return 0;
      e = GATE_NS / OSC_PER[s];
      e = (e > 2) ? e - 2 : 0;
      e = e / (p + 1);
      return (e > CMAX) ? CMAX : e;
   endfunction

   function automatic int exp_hi(input int s, input int p, input int r);
      int e;
      if (r != 0 || s >= 4) return 0;
      e = (GATE_NS / OSC_PER[s] + 2) / (p + 1);
      return (e > CMAX) ? CMAX : e;
   endfunction

   task automatic measure(input int s, input int p, input int r, input int restart_at,
                          output int got, output int blen);
      @(negedge clk);
      src = 6'(s); pre = 8'(p); rt = 2'(r); start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      blen = 0;
      while (busy && blen < 5000) begin
         blen++;
         start = (blen == restart_at);
         @(negedge clk);
      end
      start = 1'b0;
      got = int'(cnt);
   endtask

   task automatic run_check(input int s, input int p, input int r, input string tag);
      int got, blen, lo, hi;
      measure(s, p, r, 0, got, blen);
      lo = exp_lo(s, p, r);
      hi = exp_hi(s, p, r);
      chk(got >= lo && got <= hi, tag, got, lo);
      chk(blen == BUSY_LEN, "R3 busy length", blen, BUSY_LEN);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc == WDOG) begin
         total++; bad++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int got, blen, prev;
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
      chk(cnt == '0, "R1 count after reset", int'(cnt), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      chk(busy == 1'b0 && cnt == '0, "R1 idle after release", int'(cnt), 0);

      // R2: start ignored while disabled
      start = 1'b1; @(negedge clk); start = 1'b0;
      chk(busy == 1'b0, "R2 start while disabled", int'(busy), 0);
      repeat (5) @(negedge clk);
      chk(busy == 1'b0, "R2 still idle", int'(busy), 0);

      en = 1'b1;
      @(negedge clk);
      run_check(1, 0, 0, "R4 100MHz count");
      run_check(3, 0, 0, "R6 source 3 count");
      run_check(2, 0, 0, "R6 source 2 count");
      run_check(1, 3, 0, "R5 divide by 4");
      run_check(1, 255, 0, "R5 divide by 256");
      run_check(0, 0, 0, "R9 saturation");
      chk(int'(cnt) == CMAX, "R9 saturated value", int'(cnt), CMAX);
      run_check(1, 0, 1, "R7 route mode 1");
      run_check(1, 0, 3, "R7 route mode 3");
      run_check(5, 0, 0, "R6 index out of range");
      run_check(63, 0, 0, "R6 index 63");

      // R2: start pulse mid-measurement does not restart
      measure(2, 0, 0, 100, got, blen);
      chk(blen == BUSY_LEN, "R2 restart ignored length", blen, BUSY_LEN);
      chk(got >= exp_lo(2, 0, 0) && got <= exp_hi(2, 0, 0), "R2 restart ignored count",
          got, exp_lo(2, 0, 0));

      // R8: abort keeps previous result
      prev = int'(cnt);
      @(negedge clk);
      src = 6'd3; pre = 8'd0; rt = 2'd0; start = 1'b1;
      @(negedge clk); start = 1'b0;
      chk(busy == 1'b1, "R3 busy rises", int'(busy), 1);
      repeat (300) @(negedge clk);
      en = 1'b0;
      @(negedge clk);
      chk(busy == 1'b0, "R8 abort clears busy", int'(busy), 0);
      chk(int'(cnt) == prev, "R8 result kept", int'(cnt), prev);
      repeat (1200) @(negedge clk);
      chk(int'(cnt) == prev && busy == 1'b0, "R8 result kept later", int'(cnt), prev);
      en = 1'b1;
      @(negedge clk);

      for (int i = 0; i < 18; i++) begin
         int s, p, r, v;
         v = int'($urandom % 8);
         if (v < 4)       s = v;
         else if (v == 4) s = 4 + int'($urandom % 60);
         else             s = 1 + int'($urandom % 3);
         p = (($urandom % 4) == 0) ? int'($urandom % 256) : int'($urandom % 8);
         r = (($urandom % 6) == 0) ? 1 + int'($urandom % 3) : 0;
         run_check(s, p, r, "R4 R5 R6 R7 random");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule